// File: doc/BRIEF.md
# Ethernet Loopback Mode Controller

This block sits between a MAC's transmit and receive byte streams and the line side of the port. It selects the path for each frame from a small set of configuration bits. With loopback switched off, transmit bytes go to the line and line bytes go to the receive FIFO. With loopback switched on, there are four variants:

- Internal loop straight back to the receive side.
- Internal loop through an encode/decode stage. The stage is modelled here as a fixed-depth pipeline.
- True external loop. Bytes go out to the line and the returning line bytes are accepted.
- Virtual external loop. Bytes go to the line and are also copied directly to the receive side.

The block also drives the qualifiers the rest of the MAC needs:

- network transmit enable
- receive-line gating
- collision-detect enable
- link-pass override
- masked loss-of-carrier status
- effective runt-frame acceptance
- forced collision for internal loops

All data ports carry byte beats with a valid strobe and an end-of-frame flag. The configuration is sampled only while no frame is moving through the block. A frame therefore always completes under the mode it started in.

Top module: `eth_loopback_ctrl`

## Requirements
- R1: With loop enable 1, internal-loop 1 and codec-bypass 1, every transmit beat appears on the receive-FIFO port exactly 1 cycle later with unchanged data and last flag, and nothing appears on the line transmit port.
- R2: With loop enable 1, internal-loop 1 and codec-bypass 0, transmit beats reach the receive-FIFO port CODEC_STAGES+1 cycles later in order, and nothing appears on the line transmit port.
- R3: In both internal modes, net_tx_en and rx_line_gate read 0, line receive beats never reach the receive-FIFO port, and the external-loop bit changes nothing.
- R4: With loop enable 1, internal-loop 0 and external-loop 1, transmit beats appear on the line 1 cycle later and line beats reach the receive-FIFO port 1 cycle later. In this mode coll_det_en reads 0, link_force_pass reads 1, and the codec-bypass bit changes nothing.
- R5: With loop enable 1, internal-loop 0 and external-loop 0, each transmit beat appears 1 cycle later on both the line and the receive-FIFO port. Line receive beats are not forwarded, and coll_det_en and rx_line_gate read 1.
- R6: lcar_out follows carrier_lost_in with 1 cycle of delay in normal and virtual-external modes, and reads 0 in both internal modes and in true external mode.
- R7: runt_accept_eff reads 1 in every loop mode, and follows cfg_runt_accept (1 cycle later) when loop enable is 0.
- R8: force_coll reads 1 only in an internal mode with cfg_force_coll set, and reads 0 in all other modes whatever that bit is.
- R9: A configuration change made while a frame is in flight takes effect only after the frame's last beat has left the block.
- R10: Frames of any length, including a single beat, pass with every byte in order and the last flag only on the final beat.
- R11: In reset and with loop enable 0, transmit beats go to the line 1 cycle later, line beats go to the receive-FIFO port 1 cycle later, net_tx_en, rx_line_gate and coll_det_en read 1, and link_force_pass and force_coll read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_loop_en | input | 1 | Any loopback mode selected |
| cfg_int_loop | input | 1 | Internal loop select |
| cfg_codec_bypass | input | 1 | Internal loop skips the encode/decode stage |
| cfg_ext_loop | input | 1 | True external loop select (when not internal) |
| cfg_force_coll | input | 1 | Force collision on each attempt in internal loops |
| cfg_runt_accept | input | 1 | Stored runt-accept setting |
| carrier_lost_in | input | 1 | Raw loss-of-carrier from the MAC |
| txf_valid | input | 1 | Transmit FIFO beat valid |
| txf_data | input | DATA_W | Transmit FIFO byte |
| txf_last | input | 1 | Transmit FIFO end of frame |
| line_rx_valid | input | 1 | Line receive beat valid |
| line_rx_data | input | DATA_W | Line receive byte |
| line_rx_last | input | 1 | Line receive end of frame |
| line_tx_valid | output | 1 | Line transmit beat valid |
| line_tx_data | output | DATA_W | Line transmit byte |
| line_tx_last | output | 1 | Line transmit end of frame |
| rxf_valid | output | 1 | Receive FIFO beat valid |
| rxf_data | output | DATA_W | Receive FIFO byte |
| rxf_last | output | 1 | Receive FIFO end of frame |
| net_tx_en | output | 1 | Transmit to network permitted |
| rx_line_gate | output | 1 | Line receive inputs observed |
| coll_det_en | output | 1 | Collision detection enabled |
| link_force_pass | output | 1 | Link monitor forced to pass |
| lcar_out | output | 1 | Masked loss-of-carrier status |
| runt_accept_eff | output | 1 | Effective runt acceptance |
| force_coll | output | 1 | Collision forced on every attempt |

## Verification
The bench builds the block with DATA_W=8 and CODEC_STAGES=3 rather than the default depth of 2. The deeper codec path makes its latency clearly different from the one-cycle direct paths. It also keeps a frame partly inside the stage while the mode logic decides whether a change may load. The 8-bit width lets every beat carry a distinct byte, so frames of 1, 3, 4 and 40 beats can be checked for order, drops and the end-of-frame position.

// File: rtl/eth_lb_pkg.sv
package eth_lb_pkg;

  typedef enum logic [2:0] {
    LB_NORMAL     = 3'd0,
    LB_INT_DIRECT = 3'd1,
    LB_INT_CODEC  = 3'd2,
    LB_EXT_TRUE   = 3'd3,
    LB_EXT_VIRT   = 3'd4
  } lb_mode_e;

  typedef struct packed {
    logic net_tx;       // beats may leave on the line
    logic rx_gate;      // line inputs are observed
    logic rx_from_line; // receive FIFO is fed from the line
    logic tx_to_rx;     // receive FIFO is fed from transmit directly
    logic via_codec;    // receive FIFO is fed from the codec stage
    logic coll_en;      // collision detection live
    logic link_pass;    // link monitor forced to pass
    logic lcar_ok;      // loss of carrier may be reported
    logic loop_on;      // any loopback mode
    logic internal;     // internal loop (either variant)
  } lb_qual_t;

  function automatic lb_mode_e lb_decode(input logic loop_en, input logic int_loop,
                                         input logic bypass, input logic ext_loop);
    if (!loop_en)      return LB_NORMAL;
    else if (int_loop) return bypass ? LB_INT_DIRECT : LB_INT_CODEC;
    else               return ext_loop ? LB_EXT_TRUE : LB_EXT_VIRT;
  endfunction

  function automatic lb_qual_t lb_qualify(input lb_mode_e m);
    lb_qual_t q;
    q = '0;
    q.loop_on      = (m != LB_NORMAL);
    q.internal     = (m == LB_INT_DIRECT) || (m == LB_INT_CODEC);
    q.net_tx       = !q.internal;
    q.rx_gate      = !q.internal;
    q.rx_from_line = (m == LB_NORMAL) || (m == LB_EXT_TRUE);
    q.tx_to_rx     = (m == LB_INT_DIRECT) || (m == LB_EXT_VIRT);
    q.via_codec    = (m == LB_INT_CODEC);
    q.coll_en      = (m == LB_NORMAL) || (m == LB_EXT_VIRT);
    q.link_pass    = (m == LB_EXT_TRUE);
    q.lcar_ok      = (m == LB_NORMAL) || (m == LB_EXT_VIRT);
    return q;
  endfunction

endpackage

// File: rtl/eth_lb_mode_sel.sv
module eth_lb_mode_sel
  import eth_lb_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic cfg_loop_en,
  input  logic cfg_int_loop,
  input  logic cfg_codec_bypass,
  input  logic cfg_ext_loop,
  input  logic cfg_force_coll,
  input  logic cfg_runt_accept,
  input  logic carrier_lost_in,
  input  logic txf_valid,
  input  logic txf_last,
  input  logic line_rx_valid,
  input  logic line_rx_last,
  input  logic codec_busy,
  output logic net_tx,
  output logic rx_gate,
  output logic rx_from_line,
  output logic tx_to_rx,
  output logic via_codec,
  output logic coll_en,
  output logic link_pass,
  output logic force_coll,
  output logic lcar_out,
  output logic runt_accept_eff
);

  lb_qual_t qual;
  lb_qual_t dec_q;
  logic     tx_busy;
  logic     rx_busy;
  logic     line_take;
  logic     idle;

  assign dec_q     = lb_qualify(lb_decode(cfg_loop_en, cfg_int_loop, cfg_codec_bypass, cfg_ext_loop));
  assign line_take = line_rx_valid && qual.rx_from_line;
  // a new configuration is only taken while no beat is on any active path
  assign idle      = !tx_busy && !rx_busy && !txf_valid && !line_take && !codec_busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_busy         <= 1'b0;
      rx_busy         <= 1'b0;
      qual            <= lb_qualify(LB_NORMAL);
      force_coll      <= 1'b0;
      lcar_out        <= 1'b0;
      runt_accept_eff <= 1'b0;
    end else begin
      if (txf_valid) tx_busy <= !txf_last;
      if (line_take) rx_busy <= !line_rx_last;
      if (idle) begin
        qual       <= dec_q;
        force_coll <= cfg_force_coll && dec_q.internal;
      end
      lcar_out        <= carrier_lost_in && qual.lcar_ok;
      runt_accept_eff <= cfg_runt_accept || qual.loop_on;
    end
  end

  assign net_tx       = qual.net_tx;
  assign rx_gate      = qual.rx_gate;
  assign rx_from_line = qual.rx_from_line;
  assign tx_to_rx     = qual.tx_to_rx;
  assign via_codec    = qual.via_codec;
  assign coll_en      = qual.coll_en;
  assign link_pass    = qual.link_pass;

  p_mode_hold_r9: assert property (@(posedge clk) disable iff (rst)
    tx_busy |=> $stable(qual));

  p_lcar_mask_r6: assert property (@(posedge clk) disable iff (rst)
    $past(qual.link_pass || qual.internal) |-> !lcar_out);

  p_runt_force_r7: assert property (@(posedge clk) disable iff (rst)
    $past(qual.loop_on) |-> runt_accept_eff);

  p_fcoll_int_r8: assert property (@(posedge clk) disable iff (rst)
    force_coll |-> qual.internal);

endmodule

// File: rtl/eth_lb_codec_stub.sv
module eth_lb_codec_stub #(
  parameter int DATA_W = 8,
  parameter int STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_last,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data,
  output logic              out_last,
  output logic              busy
);

  logic [STAGES-1:0] stg_v;
  logic [STAGES-1:0] stg_l;
  logic [DATA_W-1:0] stg_d [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_head
      always_ff @(posedge clk) begin
        if (rst) stg_v[0] <= 1'b0;
        else     stg_v[0] <= in_valid;
      end
      always_ff @(posedge clk) begin
        stg_d[0] <= in_data;
        stg_l[0] <= in_last;
      end
    end else begin : g_body
      always_ff @(posedge clk) begin
        if (rst) stg_v[s] <= 1'b0;
        else     stg_v[s] <= stg_v[s-1];
      end
      always_ff @(posedge clk) begin
        stg_d[s] <= stg_d[s-1];
        stg_l[s] <= stg_l[s-1];
      end
    end
  end

  assign out_valid = stg_v[STAGES-1];
  assign out_data  = stg_d[STAGES-1];
  assign out_last  = stg_l[STAGES-1];
  assign busy      = |stg_v;

  p_codec_busy_r2: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> busy);

endmodule

// File: rtl/eth_lb_route.sv
module eth_lb_route #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              net_tx,
  input  logic              rx_from_line,
  input  logic              tx_to_rx,
  input  logic              via_codec,
  input  logic              txf_valid,
  input  logic [DATA_W-1:0] txf_data,
  input  logic              txf_last,
  input  logic              line_rx_valid,
  input  logic [DATA_W-1:0] line_rx_data,
  input  logic              line_rx_last,
  input  logic              cod_valid,
  input  logic [DATA_W-1:0] cod_data,
  input  logic              cod_last,
  output logic              line_tx_valid,
  output logic [DATA_W-1:0] line_tx_data,
  output logic              line_tx_last,
  output logic              rxf_valid,
  output logic [DATA_W-1:0] rxf_data,
  output logic              rxf_last
);

  logic              sel_valid;
  logic [DATA_W-1:0] sel_data;
  logic              sel_last;

  always_comb begin
    if (via_codec) begin
      sel_valid = cod_valid;
      sel_data  = cod_data;
      sel_last  = cod_last;
    end else if (tx_to_rx) begin
      sel_valid = txf_valid;
      sel_data  = txf_data;
      sel_last  = txf_last;
    end else begin
      sel_valid = line_rx_valid && rx_from_line;
      sel_data  = line_rx_data;
      sel_last  = line_rx_last;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      line_tx_valid <= 1'b0;
      rxf_valid     <= 1'b0;
    end else begin
      line_tx_valid <= txf_valid && net_tx;
      rxf_valid     <= sel_valid;
    end
  end

  always_ff @(posedge clk) begin
    line_tx_data <= txf_data;
    line_tx_last <= txf_last;
    rxf_data     <= sel_data;
    rxf_last     <= sel_last;
  end

endmodule

// File: rtl/eth_loopback_ctrl.sv
module eth_loopback_ctrl #(
  parameter int DATA_W       = 8,
  parameter int CODEC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_loop_en,
  input  logic              cfg_int_loop,
  input  logic              cfg_codec_bypass,
  input  logic              cfg_ext_loop,
  input  logic              cfg_force_coll,
  input  logic              cfg_runt_accept,
  input  logic              carrier_lost_in,
  input  logic              txf_valid,
  input  logic [DATA_W-1:0] txf_data,
  input  logic              txf_last,
  input  logic              line_rx_valid,
  input  logic [DATA_W-1:0] line_rx_data,
  input  logic              line_rx_last,
  output logic              line_tx_valid,
  output logic [DATA_W-1:0] line_tx_data,
  output logic              line_tx_last,
  output logic              rxf_valid,
  output logic [DATA_W-1:0] rxf_data,
  output logic              rxf_last,
  output logic              net_tx_en,
  output logic              rx_line_gate,
  output logic              coll_det_en,
  output logic              link_force_pass,
  output logic              lcar_out,
  output logic              runt_accept_eff,
  output logic              force_coll
);

  logic              rx_from_line;
  logic              tx_to_rx;
  logic              via_codec;
  logic              codec_busy;
  logic              cod_valid;
  logic [DATA_W-1:0] cod_data;
  logic              cod_last;

  eth_lb_mode_sel u_mode (
    .clk              (clk),
    .rst              (rst),
    .cfg_loop_en      (cfg_loop_en),
    .cfg_int_loop     (cfg_int_loop),
    .cfg_codec_bypass (cfg_codec_bypass),
    .cfg_ext_loop     (cfg_ext_loop),
    .cfg_force_coll   (cfg_force_coll),
    .cfg_runt_accept  (cfg_runt_accept),
    .carrier_lost_in  (carrier_lost_in),
    .txf_valid        (txf_valid),
    .txf_last         (txf_last),
    .line_rx_valid    (line_rx_valid),
    .line_rx_last     (line_rx_last),
    .codec_busy       (codec_busy),
    .net_tx           (net_tx_en),
    .rx_gate          (rx_line_gate),
    .rx_from_line     (rx_from_line),
    .tx_to_rx         (tx_to_rx),
    .via_codec        (via_codec),
    .coll_en          (coll_det_en),
    .link_pass        (link_force_pass),
    .force_coll       (force_coll),
    .lcar_out         (lcar_out),
    .runt_accept_eff  (runt_accept_eff)
  );

  eth_lb_codec_stub #(.DATA_W(DATA_W), .STAGES(CODEC_STAGES)) u_codec (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (txf_valid && via_codec),
    .in_data   (txf_data),
    .in_last   (txf_last),
    .out_valid (cod_valid),
    .out_data  (cod_data),
    .out_last  (cod_last),
    .busy      (codec_busy)
  );

  eth_lb_route #(.DATA_W(DATA_W)) u_route (
    .clk           (clk),
    .rst           (rst),
    .net_tx        (net_tx_en),
    .rx_from_line  (rx_from_line),
    .tx_to_rx      (tx_to_rx),
    .via_codec     (via_codec),
    .txf_valid     (txf_valid),
    .txf_data      (txf_data),
    .txf_last      (txf_last),
    .line_rx_valid (line_rx_valid),
    .line_rx_data  (line_rx_data),
    .line_rx_last  (line_rx_last),
    .cod_valid     (cod_valid),
    .cod_data      (cod_data),
    .cod_last      (cod_last),
    .line_tx_valid (line_tx_valid),
    .line_tx_data  (line_tx_data),
    .line_tx_last  (line_tx_last),
    .rxf_valid     (rxf_valid),
    .rxf_data      (rxf_data),
    .rxf_last      (rxf_last)
  );

  p_no_line_tx_int_r3: assert property (@(posedge clk) disable iff (rst)
    line_tx_valid |-> net_tx_en);

endmodule

// File: tb/eth_loopback_ctrl_tb_top.sv
module eth_loopback_ctrl_tb_top;

  localparam int DW  = 8;
  localparam int CS  = 3;
  localparam int NV  = 9;
  localparam int CAP = 64;

  // {loop,int,bypass,ext,fcoll,runt,carrier_lost} , {net,gate,coll,lpass,lcar,runt_eff,fcoll_out}
  localparam logic [13:0] VEC [NV] = '{
    14'b0000001_1110100,
    14'b0000010_1110010,
    14'b1111001_0000010,
    14'b1101101_0000011,
    14'b1110101_0000011,
    14'b1001101_1101010,
    14'b1011001_1101010,
    14'b1000101_1110110,
    14'b0100101_1110100
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_loop_en = 0, cfg_int_loop = 0, cfg_codec_bypass = 0, cfg_ext_loop = 0;
  logic cfg_force_coll = 0, cfg_runt_accept = 0, carrier_lost_in = 0;
  logic txf_valid = 0, txf_last = 0, line_rx_valid = 0, line_rx_last = 0;
  logic [DW-1:0] txf_data = '0, line_rx_data = '0;
  logic line_tx_valid, line_tx_last, rxf_valid, rxf_last;
  logic [DW-1:0] line_tx_data, rxf_data;
  logic net_tx_en, rx_line_gate, coll_det_en, link_force_pass, lcar_out, runt_accept_eff, force_coll;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  eth_loopback_ctrl #(.DATA_W(DW), .CODEC_STAGES(CS)) dut_i (
    .clk(clk), .rst(rst),
    .cfg_loop_en(cfg_loop_en), .cfg_int_loop(cfg_int_loop), .cfg_codec_bypass(cfg_codec_bypass),
    .cfg_ext_loop(cfg_ext_loop), .cfg_force_coll(cfg_force_coll), .cfg_runt_accept(cfg_runt_accept),
    .carrier_lost_in(carrier_lost_in),
    .txf_valid(txf_valid), .txf_data(txf_data), .txf_last(txf_last),
    .line_rx_valid(line_rx_valid), .line_rx_data(line_rx_data), .line_rx_last(line_rx_last),
    .line_tx_valid(line_tx_valid), .line_tx_data(line_tx_data), .line_tx_last(line_tx_last),
    .rxf_valid(rxf_valid), .rxf_data(rxf_data), .rxf_last(rxf_last),
    .net_tx_en(net_tx_en), .rx_line_gate(rx_line_gate), .coll_det_en(coll_det_en),
    .link_force_pass(link_force_pass), .lcar_out(lcar_out), .runt_accept_eff(runt_accept_eff),
    .force_coll(force_coll)
  );

  // captures of both output streams, sampled away from the active edge
  logic [DW-1:0] rx_d [CAP];
  logic          rx_l [CAP];
  int            rx_c [CAP];
  int            rx_n = 0;
  logic [DW-1:0] lt_d [CAP];
  logic          lt_l [CAP];
  int            lt_c [CAP];
  int            lt_n = 0;

  always @(negedge clk) begin
    if (rxf_valid && rx_n < CAP) begin
      rx_d[rx_n] = rxf_data; rx_l[rx_n] = rxf_last; rx_c[rx_n] = cyc; rx_n = rx_n + 1;
    end
    if (line_tx_valid && lt_n < CAP) begin
      lt_d[lt_n] = line_tx_data; lt_l[lt_n] = line_tx_last; lt_c[lt_n] = cyc; lt_n = lt_n + 1;
    end
  end

  task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic set_cfg(input logic [5:0] c);
    @(negedge clk);
    {cfg_loop_en, cfg_int_loop, cfg_codec_bypass, cfg_ext_loop, cfg_force_coll, cfg_runt_accept} = c;
    tick(3);
  endtask

  task automatic send_tx(input int n, input logic [DW-1:0] base, output int start);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (i == 0) start = cyc;
      txf_valid = 1'b1; txf_data = base + DW'(i); txf_last = (i == n - 1);
    end
    @(negedge clk);
    txf_valid = 1'b0; txf_last = 1'b0;
  endtask

  task automatic send_line(input int n, input logic [DW-1:0] base, output int start);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (i == 0) start = cyc;
      line_rx_valid = 1'b1; line_rx_data = base + DW'(i); line_rx_last = (i == n - 1);
    end
    @(negedge clk);
    line_rx_valid = 1'b0; line_rx_last = 1'b0;
  endtask

  // compare a captured run of n beats starting at index b against base+i
  task automatic chk_rx(input string tag, input int b, input int n, input logic [DW-1:0] base,
                        input int start, input int lat);
    bit ok = (rx_n == b + n);
    chk(ok, tag, "rx beat count", rx_n - b, n);
    if (ok) begin
      bit seq_ok = 1;
      for (int i = 0; i < n; i++)
        if (rx_d[b+i] != base + DW'(i) || rx_l[b+i] != (i == n - 1) || rx_c[b+i] != start + lat + i)
          seq_ok = 0;
      chk(seq_ok, tag, "rx data/last/timing first byte", int'(rx_d[b]), int'(base));
    end
  endtask

  task automatic chk_lt(input string tag, input int b, input int n, input logic [DW-1:0] base,
                        input int start);
    bit ok = (lt_n == b + n);
    chk(ok, tag, "line tx beat count", lt_n - b, n);
    if (ok) begin
      bit seq_ok = 1;
      for (int i = 0; i < n; i++)
        if (lt_d[b+i] != base + DW'(i) || lt_l[b+i] != (i == n - 1) || lt_c[b+i] != start + 1 + i)
          seq_ok = 0;
      chk(seq_ok, tag, "line tx data/last/timing first byte", int'(lt_d[b]), int'(base));
    end
  endtask

  function automatic string vec_tag(input int i);
    case (i)
      0: return "R11/R6";
      1: return "R7";
      2: return "R1/R3/R6/R7";
      3: return "R2/R3/R8";
      4: return "R8";
      5: return "R4/R6";
      6: return "R4";
      7: return "R5/R6";
      default: return "R11/R8";
    endcase
  endfunction

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual %0d expected 0", cyc);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int rb, lb, s0, s1;
    logic [6:0] got;

    // reset state (R11)
    tick(3);
    got = {net_tx_en, rx_line_gate, coll_det_en, link_force_pass, lcar_out, runt_accept_eff, force_coll};
    chk(got == 7'b1110000, "R11", "reset qualifiers", int'(got), 7'b1110000);
    chk(!line_tx_valid && !rxf_valid, "R11", "reset valids", int'({line_tx_valid, rxf_valid}), 0);
    @(negedge clk); rst = 1'b0;
    tick(2);

    // qualifier table
    for (int v = 0; v < NV; v++) begin
      @(negedge clk);
      {cfg_loop_en, cfg_int_loop, cfg_codec_bypass, cfg_ext_loop, cfg_force_coll, cfg_runt_accept,
       carrier_lost_in} = VEC[v][13:7];
      tick(2);
      got = {net_tx_en, rx_line_gate, coll_det_en, link_force_pass, lcar_out, runt_accept_eff, force_coll};
      chk(got == VEC[v][6:0], vec_tag(v), $sformatf("qualifier vector %0d", v), int'(got), int'(VEC[v][6:0]));
    end
    carrier_lost_in = 1'b0;

    // normal mode paths (R11)
    set_cfg(6'b000000);
    rb = rx_n; lb = lt_n;
    send_tx(2, 8'h10, s0);
    tick(2);
    chk_lt("R11", lb, 2, 8'h10, s0);
    chk(rx_n == rb, "R11", "tx not looped in normal", rx_n - rb, 0);
    rb = rx_n;
    send_line(3, 8'h20, s1);
    tick(2);
    chk_rx("R11", rb, 3, 8'h20, s1, 1);

    // internal direct, single beat frame, with line traffic ignored (R1, R3, R10)
    set_cfg(6'b111000);
    rb = rx_n; lb = lt_n;
    fork
      send_tx(1, 8'hA5, s0);
      send_line(2, 8'h3C, s1);
    join
    tick(2);
    chk_rx("R1", rb, 1, 8'hA5, s0, 1);
    chk(lt_n == lb, "R3", "line tx silent in internal direct", lt_n - lb, 0);
    chk(rx_n == rb + 1, "R10", "single beat frame intact", rx_n - rb, 1);

    // internal through codec, ext bit set but ignored (R2, R3)
    set_cfg(6'b110100);
    rb = rx_n; lb = lt_n;
    fork
      send_tx(3, 8'h50, s0);
      send_line(3, 8'h70, s1);
    join
    tick(CS + 3);
    chk_rx("R2", rb, 3, 8'h50, s0, CS + 1);
    chk(lt_n == lb, "R3", "line tx silent in codec loop", lt_n - lb, 0);

    // true external, bypass bit set but ignored (R4)
    set_cfg(6'b101100);
    rb = rx_n; lb = lt_n;
    send_tx(2, 8'h80, s0);
    tick(2);
    chk_lt("R4", lb, 2, 8'h80, s0);
    chk(rx_n == rb, "R4", "tx not looped directly", rx_n - rb, 0);
    send_line(2, 8'h90, s1);
    tick(2);
    chk_rx("R4", rb, 2, 8'h90, s1, 1);

    // virtual external: both copies, line receive not forwarded (R5)
    set_cfg(6'b100000);
    rb = rx_n; lb = lt_n;
    fork
      send_tx(3, 8'hC0, s0);
      send_line(1, 8'hEE, s1);
    join
    tick(2);
    chk_rx("R5", rb, 3, 8'hC0, s0, 1);
    chk_lt("R5", lb, 3, 8'hC0, s0);

    // long frame (R10)
    rb = rx_n; lb = lt_n;
    send_tx(40, 8'h01, s0);
    tick(2);
    chk_rx("R10", rb, 40, 8'h01, s0, 1);

    // mode change mid-frame (R9)
    set_cfg(6'b111000);
    rb = rx_n; lb = lt_n;
    @(negedge clk); s0 = cyc;
    txf_valid = 1'b1; txf_data = 8'h60; txf_last = 1'b0;
    @(negedge clk); txf_data = 8'h61;
    {cfg_loop_en, cfg_int_loop, cfg_codec_bypass, cfg_ext_loop} = 4'b1001;
    @(negedge clk); txf_data = 8'h62;
    chk(net_tx_en == 1'b0, "R9", "mode held during frame", int'(net_tx_en), 0);
    @(negedge clk); txf_data = 8'h63; txf_last = 1'b1;
    @(negedge clk); txf_valid = 1'b0; txf_last = 1'b0;
    tick(3);
    chk_rx("R9", rb, 4, 8'h60, s0, 1);
    chk(lt_n == lb, "R9", "no beat of frame on line", lt_n - lb, 0);
    chk(net_tx_en && link_force_pass, "R9", "new mode after frame",
        int'({net_tx_en, link_force_pass}), 3);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule